// File: doc/BRIEF.md
# Spectrum Area Accumulator

This block computes the running area between a measured spectrum and the current background estimate, which is the first half of one iteration of an iterative Shirley background fit. After a start pulse it walks a point memory from an upper index down to a lower index, both inclusive. At every point it reads a measured sample and a background sample from two synchronous RAMs with one cycle of read latency. Both samples are IEEE-754 single precision. It converts each sample to a signed fixed-point value with 32 integer and 16 fraction bits, subtracts the background from the measured value and multiplies the difference by a programmable step size. The product is added to a running total.

After each point is added, the running total is converted back to single precision. It is written to a per-point area RAM at the index of that point. When the last write has left the pipeline, the block pulses `done` and presents the total area on `amax`. The upper stage of the fit reads the area RAM and this total. The lower index must not exceed the upper index.

Top module: `spec_area_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_en`, `wr_en` and `done` are 0 and `amax` is 0.
- R2: On the clock edge that samples `start` while the block is idle, `rd_addr` becomes `hi_idx` and `rd_en` becomes 1. On each later edge the address drops by one, until the read at `lo_idx` has been issued. Exactly hi−lo+1 reads are issued.
- R3: For each index k, taken from `hi_idx` down to `lo_idx`, the block adds (measured(k) − background(k)) × step to a total that `start` cleared. It then writes the new total to `wr_addr` = k. The writes occur in strictly descending address order on consecutive cycles.
- R4: The float-to-fixed conversion behaves as follows:
  - An exponent field (bits 30:23) of 0, or a NaN, gives 0.
  - Magnitudes below 2^-16 are dropped, and other magnitudes are truncated toward zero to a multiple of 2^-16. For example, 1.5×2^-16 becomes 2^-16 (0x37800000 on output).
  - A magnitude of 2^31 or more, or an infinity, saturates to raw +(2^47−1) or −2^47.
- R5: The running total saturates instead of wrapping. A positive saturated total reads out as 0x4EFFFFFF. A negative saturated total reads out as 0xCF000000.
- R6: Output words use the following encoding:
  - The sign is in bit 31, the exponent is in bits 30:23 with bias 127, and the mantissa is in bits 22:0.
  - The mantissa is truncated.
  - A zero total is written as 0x00000000.
- R7: `done` is a one-cycle pulse on the (N+4)-th edge after the start edge, where N = hi−lo+1. On that edge `amax` takes the final total in single precision, and it holds that value until the next `done`.
- R8: A `start` pulse that arrives while a walk is in flight is ignored. The walk, its writes, its total and its timing are unchanged.
- R9: The first area write is presented on the 4th edge after the start edge, and one write follows on each later edge until all N writes are done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; clears the total and latches the bounds and the step |
| lo_idx | input | AW | Lowest index walked (inclusive) |
| hi_idx | input | AW | Highest index walked (inclusive), the first index read |
| step_f | input | 32 | Step size, single precision |
| rd_en | output | 1 | Read strobe to the measured and background RAMs |
| rd_addr | output | AW | Read address to both RAMs |
| meas_q | input | 32 | Measured sample, one cycle after its address |
| bkg_q | input | 32 | Background sample, one cycle after its address |
| wr_en | output | 1 | Write strobe to the area RAM |
| wr_addr | output | AW | Area RAM write address |
| wr_data | output | 32 | Running area, single precision |
| done | output | 1 | One-cycle pulse after the last write |
| amax | output | 32 | Total area, single precision, held between runs |

## Verification
The first read address is due on the start edge itself. The data from that read is due one edge later, the first area write four edges after the start edge, and `done` together with `amax` N+4 edges after it. The bench drives inputs and samples outputs on the falling clock edge. It counts the falling edges since the start edge and compares the cycle of the first write and the cycle of `done` with those numbers. It also collects every write together with its order, so that addresses, values and sequence are each checked against a running sum kept in real arithmetic in the bench.

// File: rtl/area_pkg.sv
package area_pkg;
  localparam int QW = 48;
  localparam int QF = 16;
  localparam int PW = 2 * QW + 1;
  localparam logic signed [QW-1:0] QMAX = {1'b0, {(QW-1){1'b1}}};
  localparam logic signed [QW-1:0] QMIN = {1'b1, {(QW-1){1'b0}}};

  // single precision -> signed fixed (truncate toward zero, saturate)
  function automatic logic signed [QW-1:0] f2q(input logic [31:0] f);
    int sh;
    logic [QW-1:0] m;
    logic [QW-1:0] mg;
    mg = {{(QW-24){1'b0}}, 1'b1, f[22:0]};
    if (f[30:23] == 8'd0) return '0;
    if (f[30:23] == 8'hFF) begin
      if (f[22:0] != 23'd0) return '0;
      return f[31] ? QMIN : QMAX;
    end
    sh = int'(f[30:23]) - (150 - QF);
    if (sh >= QW - 24) return f[31] ? QMIN : QMAX;
    else if (sh >= 0) m = mg << sh;
    else if (sh > -24) m = mg >> (-sh);
    else m = '0;
    return f[31] ? -$signed(m) : $signed(m);
  endfunction

  // signed fixed -> single precision (mantissa truncated)
  function automatic logic [31:0] q2f(input logic signed [QW-1:0] q);
    logic [QW-1:0] mag;
    logic [QW-1:0] t;
    int p;
    if (q == '0) return 32'd0;
    mag = q[QW-1] ? (~q + 1'b1) : q;
    p = 0;
    for (int i = 0; i < QW; i++) if (mag[i]) p = i;
    if (p >= 23) t = mag >> (p - 23);
    else t = mag << (23 - p);
    return {q[QW-1], 8'(p + 127 - QF), t[22:0]};
  endfunction

  // difference times step, back to fixed scale, saturated
  function automatic logic signed [QW-1:0] scale(input logic signed [QW:0] d,
                                                input logic signed [QW-1:0] s);
    logic signed [PW-1:0] p;
    logic signed [PW-1:0] r;
    p = $signed({{(QW){d[QW]}}, d}) * $signed({{(QW+1){s[QW-1]}}, s});
    r = p >>> QF;
    if (r[PW-1:QW-1] == {(PW-QW+1){1'b0}} || r[PW-1:QW-1] == {(PW-QW+1){1'b1}})
      return r[QW-1:0];
    return r[PW-1] ? QMIN : QMAX;
  endfunction

  function automatic logic signed [QW-1:0] sat_add(input logic signed [QW-1:0] a,
                                                  input logic signed [QW-1:0] b);
    logic signed [QW:0] s;
    s = {a[QW-1], a} + {b[QW-1], b};
    if (s[QW] != s[QW-1]) return s[QW] ? QMIN : QMAX;
    return s[QW-1:0];
  endfunction
endpackage

// File: rtl/area_walker.sv
module area_walker #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fin,
  input  logic [AW-1:0] lo_idx,
  input  logic [AW-1:0] hi_idx,
  output logic          start_ok,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          rd_last,
  output logic [AW-1:0] lo_q,
  output logic [AW-1:0] hi_q
);
  logic          busy;
  logic [AW-1:0] nxt_addr;

  assign start_ok = start & ~busy;
  assign nxt_addr = rd_addr - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      rd_last <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      if (start_ok) begin
        busy    <= 1'b1;
        lo_q    <= lo_idx;
        hi_q    <= hi_idx;
        rd_en   <= 1'b1;
        rd_addr <= hi_idx;
        rd_last <= (hi_idx == lo_idx);
      end else if (rd_en) begin
        if (rd_last) begin
          rd_en <= 1'b0;
        end else begin
          rd_addr <= nxt_addr;
          rd_last <= (nxt_addr == lo_q);
        end
      end
      if (fin) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/area_datapath.sv
module area_datapath
  import area_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [31:0]   step_f,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_last,
  input  logic [31:0]   meas_q,
  input  logic [31:0]   bkg_q,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          done,
  output logic [31:0]   amax
);
  logic                 v0, v1, v2, wr_last;
  logic                 l0, l1, l2;
  logic [AW-1:0]        a0, a1, a2;
  logic signed [QW:0]   diff1;
  logic signed [QW-1:0] prod2, step_q, acc, acc_nx;

  always_comb acc_nx = sat_add(acc, prod2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0 <= 1'b0; v1 <= 1'b0; v2 <= 1'b0;
      l0 <= 1'b0; l1 <= 1'b0; l2 <= 1'b0;
      a0 <= '0;   a1 <= '0;   a2 <= '0;
      diff1   <= '0;
      prod2   <= '0;
      step_q  <= '0;
      acc     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_last <= 1'b0;
      done    <= 1'b0;
      amax    <= '0;
    end else begin
      // stage 0: align with RAM read latency
      v0 <= rd_en;
      a0 <= rd_addr;
      l0 <= rd_last & rd_en;
      // stage 1: convert and subtract
      v1 <= v0;
      a1 <= a0;
      l1 <= l0;
      if (v0) diff1 <= {f2q(meas_q)[QW-1], f2q(meas_q)} - {f2q(bkg_q)[QW-1], f2q(bkg_q)};
      // stage 2: scale by step
      v2 <= v1;
      a2 <= a1;
      l2 <= l1;
      if (v1) prod2 <= scale(diff1, step_q);
      // stage 3: accumulate and write
      wr_en   <= v2;
      wr_addr <= a2;
      wr_last <= v2 & l2;
      if (v2) begin
        acc     <= acc_nx;
        wr_data <= q2f(acc_nx);
      end
      if (clear) begin
        acc    <= '0;
        step_q <= f2q(step_f);
      end
      done <= wr_en & wr_last;
      if (wr_en && wr_last) amax <= q2f(acc);
    end
  end
endmodule

// File: rtl/spec_area_unit.sv
module spec_area_unit #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] lo_idx,
  input  logic [AW-1:0] hi_idx,
  input  logic [31:0]   step_f,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   meas_q,
  input  logic [31:0]   bkg_q,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          done,
  output logic [31:0]   amax
);
  logic          start_ok;
  logic          rd_last;
  logic [AW-1:0] lo_w, hi_w;

  area_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .fin(done),
    .lo_idx(lo_idx), .hi_idx(hi_idx), .start_ok(start_ok),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_last(rd_last),
    .lo_q(lo_w), .hi_q(hi_w)
  );

  area_datapath #(.AW(AW)) u_dp (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .step_f(step_f),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_last(rd_last),
    .meas_q(meas_q), .bkg_q(bkg_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .amax(amax)
  );
endmodule

// File: rtl/area_chk.sv
module area_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_ok,
  input logic [AW-1:0] hi_idx,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] lo_w,
  input logic [AW-1:0] hi_w,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          done
);
  assert_walk_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (rd_en && rd_addr == $past(hi_idx)));

  assert_walk_bounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr >= lo_w && rd_addr <= hi_w));

  assert_write_descend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) - 1'b1));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !$past(start_ok) && $past(rd_en)) |-> (rd_addr == $past(rd_addr) - 1'b1));
endmodule

bind spec_area_unit area_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .hi_idx(hi_idx),
  .rd_en(rd_en), .rd_addr(rd_addr), .lo_w(lo_w), .hi_w(hi_w),
  .wr_en(wr_en), .wr_addr(wr_addr), .done(done)
);

// File: tb/sim_spec_area_unit.sv
module sim_spec_area_unit;
  localparam int AW = 6;
  localparam int D = 1 << AW;
  localparam int NV = 6;
  // stimulus table: lo, hi, step in quarters, restart mid-walk, expected point count
  localparam int V_LO [NV] = '{0, 10, 5, 0, 30, 62};
  localparam int V_HI [NV] = '{63, 20, 5, 0, 40, 63};
  localparam int V_SQ [NV] = '{2, 8, 4, 1, 12, 4};
  localparam int V_MID[NV] = '{1, 0, 0, 1, 0, 0};
  localparam int V_N  [NV] = '{64, 11, 1, 1, 11, 2};

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] lo_idx = '0, hi_idx = '0;
  logic [31:0] step_f = '0;
  logic rd_en, wr_en, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [31:0] meas_q, bkg_q, wr_data, amax;

  logic [31:0] dmem [D];
  logic [31:0] bmem [D];
  logic [31:0] cap  [D];
  int          wseq [D];
  int          wcnt = 0;
  int          total = 0, fails = 0;

  always #10 clk = ~clk;

  spec_area_unit #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .lo_idx(lo_idx), .hi_idx(hi_idx),
    .step_f(step_f), .rd_en(rd_en), .rd_addr(rd_addr), .meas_q(meas_q),
    .bkg_q(bkg_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .amax(amax)
  );

  always @(posedge clk) begin
    meas_q <= dmem[rd_addr];
    bkg_q  <= bmem[rd_addr];
    if (wr_en) begin
      cap[wr_addr] <= wr_data;
      if (wcnt < D) wseq[wcnt] <= int'(wr_addr);
      wcnt <= wcnt + 1;
    end
  end

  function automatic logic [31:0] sp(input real r);
    logic [63:0] b;
    if (r == 0.0) return 32'd0;
    b = $realtobits(r);
    return {b[63], 8'(int'(b[62:52]) - 1023 + 127), b[51:29]};
  endfunction

  function automatic real dval(input int k);
    return real'((k * 3) % 17 + 4);
  endfunction

  function automatic real bval(input int k);
    return real'(k) * 0.25;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // run one walk; exp_a2 indexed by point, exp_tot total word
  task automatic run(input int lo, input int hi, input logic [31:0] stp, input bit mid,
                     input logic [31:0] exp_a2 [D], input logic [31:0] exp_tot);
    int n, fw, dn, base, bad, badk, nexp;
    logic [31:0] held;
    nexp = hi - lo + 1;
    base = wcnt;
    n = 0; fw = -1; dn = -1;
    @(negedge clk);
    lo_idx = AW'(lo); hi_idx = AW'(hi); step_f = stp; start = 1;
    while (n < 400) begin
      @(negedge clk);
      n++;
      start = (mid && n == 2);
      if (mid && n == 2) begin lo_idx = '0; hi_idx = '1; step_f = 32'h40800000; end
      if (wr_en && fw < 0) fw = n;
      if (done) begin dn = n; break; end
    end
    start = 0;
    chk(fw - 1 == 4, "R9", "first write cycle", fw - 1, 4);
    chk(dn - 1 == nexp + 4, mid ? "R7/R8" : "R7", "done cycle", dn - 1, nexp + 4);
    chk(wcnt - base == nexp, "R2", "write count", wcnt - base, nexp);
    bad = 0; badk = 0;
    for (int i = 0; i < nexp && base + i < D; i++)
      if (wseq[base + i] != hi - i && bad == 0) begin bad = 1; badk = i; end
    chk(bad == 0, "R3", "write order", wseq[base + badk], hi - badk);
    bad = 0; badk = lo;
    for (int k = hi; k >= lo; k--)
      if (cap[k] !== exp_a2[k] && bad == 0) begin bad = 1; badk = k; end
    chk(bad == 0, mid ? "R3/R8" : "R3", "area word", cap[badk], exp_a2[badk]);
    chk(amax === exp_tot, "R7", "amax at done", amax, exp_tot);
    held = amax;
    @(negedge clk);
    chk(!done && amax === held, "R7", "done pulse/held total", {done, amax}, {1'b0, held});
  endtask

  initial begin
    logic [31:0] ea [D];
    real acc, stp;
    for (int k = 0; k < D; k++) begin
      dmem[k] = sp(dval(k)); bmem[k] = sp(bval(k)); ea[k] = '0; cap[k] = '0; wseq[k] = -1;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!rd_en && !wr_en && !done && amax == 0, "R1", "outputs in reset",
        {rd_en, wr_en, done, amax}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rd_en && !wr_en && !done && amax == 0, "R1", "outputs after reset",
        {rd_en, wr_en, done, amax}, 0);

    // table of stimulus vectors (R2 R3 R6 R7 R8 R9)
    for (int v = 0; v < NV; v++) begin
      stp = real'(V_SQ[v]) / 4.0;
      acc = 0.0;
      for (int k = V_HI[v]; k >= V_LO[v]; k--) begin
        acc = acc + (dval(k) - bval(k)) * stp;
        ea[k] = sp(acc);
      end
      chk(V_HI[v] - V_LO[v] + 1 == V_N[v], "R2", "table point count", V_HI[v] - V_LO[v] + 1, V_N[v]);
      run(V_LO[v], V_HI[v], sp(stp), V_MID[v] != 0, ea, sp(acc));
    end

    // R4 R5: positive saturation at input and in the total
    dmem[1] = 32'h53800000; bmem[1] = 32'h0;
    dmem[2] = 32'h53800000; bmem[2] = 32'h0;
    ea[2] = sp(2.0**31 - 2.0**-16); ea[1] = ea[2];
    chk(ea[2] == 32'h4EFFFFFF, "R5", "bench max word", ea[2], 32'h4EFFFFFF);
    run(1, 2, 32'h3F800000, 0, ea, ea[2]);

    // R4 R5: negative infinity saturates, total clamps at most negative
    dmem[4] = 32'hC0000000; bmem[4] = 32'h0;
    dmem[3] = 32'hFF800000; bmem[3] = 32'h0;
    ea[4] = 32'hC0000000; ea[3] = sp(-(2.0**31));
    run(3, 4, 32'h3F800000, 0, ea, 32'hCF000000);

    // R4 R6: NaN, denormal and tiny inputs read as zero; zero total word
    dmem[7] = 32'h35800000; bmem[7] = 32'hBF800000;
    dmem[6] = 32'h00000001; bmem[6] = 32'h0;
    dmem[5] = 32'h7FC00000; bmem[5] = 32'h3F800000;
    ea[7] = 32'h3F800000; ea[6] = 32'h3F800000; ea[5] = 32'h0;
    run(5, 7, 32'h3F800000, 0, ea, 32'h0);

    // R4: fraction truncated toward zero to one fixed step
    dmem[8] = 32'h37C00000; bmem[8] = 32'h0;
    ea[8] = 32'h37800000;
    run(8, 8, 32'h3F800000, 0, ea, 32'h37800000);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++; fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule